// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Request

This block holds the status word of one serial channel and turns it into a single interrupt request. The status word mixes three kinds of bit. Some are live levels: receive data waiting, receive overrun, and the four modem inputs (carrier detect, data set ready, clear to send, ring indicator). Others are sticky change events, one for each modem input. The last is a gated transmit-empty flag. Each modem input passes through a two-flop synchronizer. Any edge of the synchronized level sets that input's change event.

Software reads the status word and writes it back to acknowledge it. Only the change-event bits respond to a written 1, which clears them. Every other bit ignores writes, so writing back a value just read acknowledges exactly the events that were seen. A second address holds three interrupt-enable bits: modem events, receive data, and transmit empty. The request output is the OR of every enabled source.

All pins are plain control and status signals with no handshake. A register write takes effect on the clock edge at which `reg_wr` is sampled high. Reads are combinational on `reg_addr`.

Top module: `chstat_top`

## Requirements
- R1: After reset, with all inputs low, the status word (`reg_addr`=0) reads 0, the enable word (`reg_addr`=1) reads 0, and `irq` is 0.
- R2: Status bit 0 follows `rx_avail` and bit 13 follows `rx_overrun`, both in the same cycle. Bits 3, 4, 5 and 6 show the synchronized levels of carrier detect, data set ready, clear to send and ring indicator. Each of these level bits changes after the second rising edge that samples the new pin value. Status bits not named in R2, R3 or R7 read 0.
- R3: A change event is set one clock edge after the matching level bit changes, on either a rising or a falling edge of that level. The event bits are: data set ready in bit 16, clear to send in bit 17, carrier detect in bit 18, and ring indicator in bit 22. A set event stays set until it is cleared.
- R4: A write to the status address clears each event bit whose written bit is 1. Written zeros, and writes to any non-event status bit, change nothing, so writing back a word that was read clears only the events it showed.
- R5: If an event occurs on the same edge as a write of 1 to that event's bit, the event wins and the bit reads 1 afterwards.
- R6: A write to the enable address stores bit 0 (modem-event enable), bit 2 (receive enable) and bit 19 (transmit enable). All other bits of the enable word read 0.
- R7: Status bit 25 equals `tx_empty` while enable bit 19 is set, and reads 0 otherwise.
- R8: `irq` is 1 exactly when at least one of these holds: enable bit 2 and `rx_avail` are both 1; enable bit 19 and `tx_empty` are both 1; enable bit 0 is 1 and any event bit is set. This is combinational on the current state and inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 1 | 0 selects the status word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| dcd_in | input | 1 | Carrier detect pin, asynchronous |
| dsr_in | input | 1 | Data set ready pin, asynchronous |
| cts_in | input | 1 | Clear to send pin, asynchronous |
| ri_in | input | 1 | Ring indicator pin, asynchronous |
| rx_avail | input | 1 | Receive data available, from the datapath |
| rx_overrun | input | 1 | Receive overrun, from the datapath |
| tx_empty | input | 1 | Transmit empty, from the datapath |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench targets four corner cases.

Write-back acknowledge: it writes back a word that holds both a live carrier level and its event. A design that let level bits take writes, or that cleared on written zeros, would show a wrong word afterwards.

Clear racing a new edge: it times a clear to land on the same edge as a new modem edge. A design that gave the clear priority would lose that event.

Synchronizer latency: it counts the edges from pin to level bit to event bit. An extra or missing stage shows up as a shifted bit.

Enable gating: it masks the transmit enable while `tx_empty` is high. This catches a design that reports transmit-empty or raises `irq` without the enable.

A long pseudo-random stretch then mixes pin edges, writes to both addresses and datapath levels against the cycle model.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
  localparam int REG_W   = 32;
  localparam int N_MODEM = 4;   // 0 carrier, 1 dsr, 2 cts, 3 ring

  localparam int POS_RXAV = 0;
  localparam int POS_OVR  = 13;
  localparam int POS_TXE  = 25;

  localparam int EN_MS = 0;
  localparam int EN_RX = 2;
  localparam int EN_TX = 19;

  localparam logic ADDR_CTRL = 1'b1;

  function automatic int lvl_pos(input int idx);
    return 3 + idx;
  endfunction

  function automatic int ev_pos(input int idx);
    case (idx)
      0:       return 18;
      1:       return 16;
      2:       return 17;
      default: return 22;
    endcase
  endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign edge_o  = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/event_bank.sv
module event_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;   // new event beats clear
  end
endmodule

// File: rtl/chstat_ctrl.sv
module chstat_ctrl
  import chstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             ms_d,
  input  logic             rx_d,
  input  logic             tx_d,
  output logic             en_ms_o,
  output logic             en_rx_o,
  output logic             en_tx_o,
  output logic [REG_W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ms_o <= 1'b0;
      en_rx_o <= 1'b0;
      en_tx_o <= 1'b0;
    end else if (wr_i) begin
      en_ms_o <= ms_d;
      en_rx_o <= rx_d;
      en_tx_o <= tx_d;
    end
  end

  always_comb begin
    word_o        = '0;
    word_o[EN_MS] = en_ms_o;
    word_o[EN_RX] = en_rx_o;
    word_o[EN_TX] = en_tx_o;
  end
endmodule

// File: rtl/chstat_top.sv
module chstat_top
  import chstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dcd_in,
  input  logic             dsr_in,
  input  logic             cts_in,
  input  logic             ri_in,
  input  logic             rx_avail,
  input  logic             rx_overrun,
  input  logic             tx_empty,
  output logic             irq
);
  logic [N_MODEM-1:0] pins, mlvl, mtog, ev_clr, ev_q;
  logic [REG_W-1:0]   stat_word, ctrl_word;
  logic               en_ms, en_rx, en_tx;
  logic               stat_wr, ctrl_wr;
  logic               wdata_unused;

  assign pins         = {ri_in, cts_in, dsr_in, dcd_in};
  assign stat_wr      = reg_wr && (reg_addr != ADDR_CTRL);
  assign ctrl_wr      = reg_wr && (reg_addr == ADDR_CTRL);
  assign wdata_unused = ^reg_wdata;

  for (genvar gi = 0; gi < N_MODEM; gi++) begin : g_modem
    modem_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pins[gi]),
      .level_o (mlvl[gi]),
      .edge_o  (mtog[gi])
    );
    assign ev_clr[gi] = stat_wr && reg_wdata[ev_pos(gi)];
  end

  event_bank #(.N(N_MODEM)) u_ev (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (mtog),
    .clr_i (ev_clr),
    .q_o   (ev_q)
  );

  chstat_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctrl_wr),
    .ms_d    (reg_wdata[EN_MS]),
    .rx_d    (reg_wdata[EN_RX]),
    .tx_d    (reg_wdata[EN_TX]),
    .en_ms_o (en_ms),
    .en_rx_o (en_rx),
    .en_tx_o (en_tx),
    .word_o  (ctrl_word)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[POS_RXAV] = rx_avail;
    stat_word[POS_OVR]  = rx_overrun;
    stat_word[POS_TXE]  = tx_empty && en_tx;
    for (int i = 0; i < N_MODEM; i++) begin
      stat_word[lvl_pos(i)] = mlvl[i];
      stat_word[ev_pos(i)]  = ev_q[i];
    end
  end

  assign reg_rdata = (reg_addr == ADDR_CTRL) ? ctrl_word : stat_word;
  assign irq = (en_rx && rx_avail) || (en_tx && tx_empty) || (en_ms && (|ev_q));
endmodule

// File: rtl/chstat_checker.sv
module chstat_checker
  import chstat_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_addr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic               rx_avail,
  input logic               tx_empty,
  input logic               irq,
  input logic [REG_W-1:0]   stat_word,
  input logic [REG_W-1:0]   ctrl_word,
  input logic [N_MODEM-1:0] ev_set
);
  for (genvar gi = 0; gi < N_MODEM; gi++) begin : g_ev
    // R3: an event bit holds until a 1 is written to it
    a_r3_event_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word[ev_pos(gi)] && !(reg_wr && !reg_addr && reg_wdata[ev_pos(gi)]))
        |=> stat_word[ev_pos(gi)]);
    // R4: a written 1 with no new edge clears the bit
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_addr && reg_wdata[ev_pos(gi)] && !ev_set[gi])
        |=> !stat_word[ev_pos(gi)]);
    // R5: a new edge always leaves the bit set
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[gi] |=> stat_word[ev_pos(gi)]);
  end

  // R6: only the three enable bits are stored
  a_r6_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr) |=> (ctrl_word == ($past(reg_wdata) & 32'h0008_0005)));

  // R7: transmit-empty is hidden without its enable
  a_r7_txe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[EN_TX] |-> !stat_word[POS_TXE]);

  // R8: enabled sources raise the request, no enables means no request
  a_r8_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[EN_RX] && rx_avail) |-> irq);
  a_r8_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[EN_TX] && tx_empty) |-> irq);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word == '0) |-> !irq);
endmodule

bind chstat_top chstat_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rx_avail  (rx_avail),
  .tx_empty  (tx_empty),
  .irq       (irq),
  .stat_word (stat_word),
  .ctrl_word (ctrl_word),
  .ev_set    (mtog)
);

// File: tb/sim_chstat_top.sv
module sim_chstat_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dcd_in = 1'b0, dsr_in = 1'b0, cts_in = 1'b0, ri_in = 1'b0;
  logic        rx_avail = 1'b0, rx_overrun = 1'b0, tx_empty = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  chstat_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dcd_in(dcd_in), .dsr_in(dsr_in), .cts_in(cts_in), .ri_in(ri_in),
    .rx_avail(rx_avail), .rx_overrun(rx_overrun), .tx_empty(tx_empty),
    .irq(irq)
  );

  // reference model: pin sample history (newest first), events, enables
  logic [3:0]  hist[$];
  logic [3:0]  ev_m;
  logic [31:0] ctl_m;

  function automatic int evb(input int i);
    case (i)
      0: return 18;
      1: return 16;
      2: return 17;
      default: return 22;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [3:0] changed;
    if (!rst_n) begin
      hist  = {4'h0, 4'h0, 4'h0};
      ev_m  = '0;
      ctl_m = '0;
    end else begin
      changed = hist[1] ^ hist[2];
      for (int i = 0; i < 4; i++) begin
        if (reg_wr && !reg_addr && reg_wdata[evb(i)]) ev_m[i] = 1'b0;
        if (changed[i]) ev_m[i] = 1'b1;
      end
      if (reg_wr && reg_addr) ctl_m = reg_wdata & 32'h0008_0005;
      hist.push_front({ri_in, cts_in, dsr_in, dcd_in});
      void'(hist.pop_back());
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[0]  = rx_avail;
    s[13] = rx_overrun;
    s[25] = tx_empty & ctl_m[19];
    for (int i = 0; i < 4; i++) begin
      s[3+i]    = hist[1][i];
      s[evb(i)] = ev_m[i];
    end
    return s;
  endfunction

  task automatic compare();
    logic [31:0] es = exp_status();
    logic        ei;
    if (!reg_addr) begin
      chk("R2 levels", reg_rdata & 32'h0000_2079, es & 32'h0000_2079);
      chk("R3 events", reg_rdata & 32'h0047_0000, es & 32'h0047_0000);
      chk("R7 txe",    reg_rdata & 32'h0200_0000, es & 32'h0200_0000);
      chk("R2 zeros",  reg_rdata & ~32'h0247_2079, 32'h0);
    end else begin
      chk("R6 enables", reg_rdata, ctl_m);
    end
    ei = (ctl_m[2] & rx_avail) | (ctl_m[19] & tx_empty) | (ctl_m[0] & (|ev_m));
    chk("R8 irq", {31'b0, irq}, {31'b0, ei});
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    compare();
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    hist = {4'h0, 4'h0, 4'h0};
    ev_m = '0;
    ctl_m = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    reg_addr = 1'b0; #1;
    chk("R1 status", reg_rdata, 32'h0);
    reg_addr = 1'b1; #1;
    chk("R1 enables", reg_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    reg_addr = 1'b0;

    // R3: rising carrier gives level after 2 edges, event after 3
    dcd_in = 1'b1;
    tick(); tick();
    chk("R2 carrier level", reg_rdata, 32'h0000_0008);
    tick();
    chk("R3 carrier event", reg_rdata, 32'h0004_0008);

    // R4: zero write does nothing, write-back clears only the event
    wr(1'b0, 32'h0000_0000);
    chk("R4 zero write", reg_rdata, 32'h0004_0008);
    wr(1'b0, 32'h0004_0008);
    chk("R4 write back", reg_rdata, 32'h0000_0008);

    // R5: falling edge event collides with a clear
    dcd_in = 1'b0;
    tick(); tick();
    chk("R5 pre", reg_rdata, 32'h0000_0000);
    wr(1'b0, 32'h0004_0000);
    chk("R5 set wins", reg_rdata, 32'h0004_0000);

    // R6: only three enable bits stick
    wr(1'b1, 32'hFFFF_FFFF);
    reg_addr = 1'b1; #1;
    chk("R6 readback", reg_rdata, 32'h0008_0005);
    reg_addr = 1'b0; #1;
    chk("R8 modem irq", {31'b0, irq}, 32'h1);
    wr(1'b0, 32'h0004_0000);
    chk("R8 irq after ack", {31'b0, irq}, 32'h0);

    // R7: transmit-empty gated by enable bit 19
    tx_empty = 1'b1; #1;
    chk("R7 txe shown", reg_rdata, 32'h0200_0000);
    chk("R8 tx irq", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h0000_0005);
    chk("R7 txe hidden", reg_rdata, 32'h0000_0000);
    chk("R8 tx masked", {31'b0, irq}, 32'h0);

    // R2: datapath levels are immediate
    rx_avail = 1'b1; rx_overrun = 1'b1; #1;
    chk("R2 rx and overrun", reg_rdata, 32'h0000_2001);
    chk("R8 rx irq", {31'b0, irq}, 32'h1);
    rx_avail = 1'b0; rx_overrun = 1'b0; tx_empty = 1'b0;
    tick();

    // mixed stretch against the model (R2, R3, R4, R6, R7, R8)
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:2] == 2'b00) {ri_in, cts_in, dsr_in, dcd_in} = lfsr[15:12];
      rx_avail   = lfsr[16];
      rx_overrun = lfsr[17];
      tx_empty   = lfsr[18];
      reg_addr   = lfsr[8];
      reg_wr     = (lfsr[7:5] == 3'b000);
      reg_wdata  = {lfsr[11:0], lfsr[31:12]} ^ lfsr;
      tick();
    end
    reg_wr = 1'b0;
    tick();
    finish_run();
  end
endmodule